// File: doc/BRIEF.md
# Crossbar Input Request Generator

This block sits at one input port of an iterative request-grant-accept crossbar scheduler. Each slot it raises one request line for each output whose virtual output queue at this input holds cells. It does this for a fixed number of iterations, and it stops requesting as soon as the local accept arbiter reports that this input has been granted. The stage is pipelined: the requests of iteration k+1 are on the wires in the same cycle that the accept decision of iteration k comes back.

A connection made in the previous slot can carry over into the new one. At the slot-start pulse, the previous connection vector is combined with the per-output keep flags from the quota logic. A connection is held only while its queue is still non-empty. A held connection makes the input start the slot already matched and silences all of its requests. The block also drives a per-output disable vector that switches off the grant and accept arbiters for that pair for the whole slot.

Top module: `xbar_req_gen`

## Requirements
- R1: While reset is high and in the first cycle after it, the outputs read as follows: `req_o`, `hold_dis_o` and `matched_o` are all zero, `issue_o` is 0 and `iter_o` is 0.
- R2: In the cycle after a `slot_start_i` pulse that holds no connection, `issue_o` is 1, `iter_o` is 0, `matched_o` is 0 and `req_o` equals the `voq_ne_i` value seen in the pulse cycle.
- R3: While unmatched in a request phase, `req_o` in each iteration cycle equals the `voq_ne_i` value of the cycle before. Bit j of `req_o` stands for output j.
- R4: If `any_grant_i` is 1 in a cycle that is not a slot start, then from the next cycle `matched_o` is 1 and `req_o` is zero until the next slot start.
- R5: Each slot has exactly NITER request cycles, with `iter_o` counting 0 to NITER-1 (default NITER = 3). After the last of them, `issue_o`, `iter_o` and `req_o` return to zero.
- R6: At a slot start, `hold_dis_o` takes `prev_conn_i & keep_i & voq_ne_i`. If that vector is non-zero, `matched_o` is 1 and `req_o` stays zero for the whole slot.
- R7: A previous connection whose keep flag is set but whose queue is empty at slot start is dropped. Its `hold_dis_o` bit is 0 and the input requests as an unmatched input.
- R8: `hold_dis_o` changes only in the cycle after a slot-start pulse.
- R9: A slot-start pulse during a running slot restarts it. The matched state is cleared or reloaded from the hold vector, and iteration 0 is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_start_i | input | 1 | One-cycle pulse that begins a slot |
| voq_ne_i | input | N | Per-output queue non-empty flags |
| any_grant_i | input | 1 | Local accept arbiter received at least one grant |
| prev_conn_i | input | N | Connection of this input in the previous slot (one-hot or zero) |
| keep_i | input | N | Per-output keep flags from the quota logic |
| req_o | output | N | Registered request lines, one per output |
| hold_dis_o | output | N | Arbiter disable for a held connection, per output |
| matched_o | output | 1 | Input is matched in the current slot |
| issue_o | output | 1 | A request iteration is being issued this cycle |
| iter_o | output | IW | Index of the iteration being issued |

## Verification
A matched flag that fails to set would show up one cycle after the grant as a request line that is still raised. Because the lines are registered, that error is visible on the very next clock. A wrong iteration count shows as one request cycle too many or too few at the end of the slot. A corrupted hold capture shows in the cycle after the slot start, as a wrong disable vector and as requests that should have been silenced. The bench runs a behavioural model beside the design and compares all outputs on every clock, so each of these faults is reported within a cycle of its cause.

// File: rtl/xbar_req_pkg.sv
package xbar_req_pkg;

    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_ISSUE = 1'b1
    } phase_e;

    typedef struct packed {
        logic start;  // slot begins at this edge
        logic more;   // another iteration follows the one on the wires
    } seq_ctl_t;

    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/xbar_req_seq.sv
module xbar_req_seq
    import xbar_req_pkg::*;
#(
    parameter int NITER = 3,
    localparam int IW = idx_bits(NITER)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          slot_start_i,
    output seq_ctl_t      ctl_o,
    output logic          issue_o,
    output logic [IW-1:0] iter_o
);

    localparam logic [IW-1:0] LAST = IW'(NITER - 1);
    localparam logic [IW-1:0] ONE  = IW'(1);

    phase_e        phase_q;
    logic [IW-1:0] iter_q;
    logic          at_last;

    assign at_last = (iter_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            iter_q  <= '0;
        end else if (slot_start_i) begin
            phase_q <= PH_ISSUE;
            iter_q  <= '0;
        end else if (phase_q == PH_ISSUE) begin
            if (at_last) begin
                phase_q <= PH_IDLE;
                iter_q  <= '0;
            end else begin
                iter_q <= iter_q + ONE;
            end
        end
    end

    always_comb begin
        ctl_o.start = slot_start_i;
        ctl_o.more  = (phase_q == PH_ISSUE) && !at_last;
    end

    assign issue_o = (phase_q == PH_ISSUE);
    assign iter_o  = iter_q;

    // R5
    iter_range_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE) |-> (iter_q == '0));

endmodule

// File: rtl/xbar_req_hold.sv
module xbar_req_hold #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic [N-1:0] prev_i,
    input  logic [N-1:0] keep_i,
    input  logic [N-1:0] voq_ne_i,
    output logic         hold_next_any_o,
    output logic [N-1:0] hold_o
);

    logic [N-1:0] hold_next;

    for (genvar j = 0; j < N; j++) begin : g_pair
        // a held pair survives only while its queue still has cells
        assign hold_next[j] = prev_i[j] & keep_i[j] & voq_ne_i[j];

        always_ff @(posedge clk) begin
            if (rst) begin
                hold_o[j] <= 1'b0;
            end else if (start_i) begin
                hold_o[j] <= hold_next[j];
            end
        end
    end

    assign hold_next_any_o = |hold_next;

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> $stable(hold_o));

endmodule

// File: rtl/xbar_req_lines.sv
module xbar_req_lines
    import xbar_req_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  seq_ctl_t     ctl_i,
    input  logic         hold_next_any_i,
    input  logic [N-1:0] voq_ne_i,
    input  logic         any_grant_i,
    output logic [N-1:0] req_o,
    output logic         matched_o
);

    logic matched_q;
    logic matched_next;
    logic quiet_next;

    // matched state the next iteration will see
    always_comb begin
        if (ctl_i.start) begin
            matched_next = hold_next_any_i;
        end else begin
            matched_next = matched_q | any_grant_i;
        end
        quiet_next = matched_next | !(ctl_i.start | ctl_i.more);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            matched_q <= 1'b0;
        end else begin
            matched_q <= matched_next;
        end
    end

    for (genvar j = 0; j < N; j++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                req_o[j] <= 1'b0;
            end else begin
                req_o[j] <= voq_ne_i[j] & !quiet_next;
            end
        end
    end

    assign matched_o = matched_q;

    // R4
    matched_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (matched_q && !ctl_i.start) |=> (req_o == '0));

endmodule

// File: rtl/xbar_req_gen.sv
module xbar_req_gen
    import xbar_req_pkg::*;
#(
    parameter int N     = 4,
    parameter int NITER = 3,
    localparam int IW = idx_bits(NITER)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          slot_start_i,
    input  logic [N-1:0]  voq_ne_i,
    input  logic          any_grant_i,
    input  logic [N-1:0]  prev_conn_i,
    input  logic [N-1:0]  keep_i,
    output logic [N-1:0]  req_o,
    output logic [N-1:0]  hold_dis_o,
    output logic          matched_o,
    output logic          issue_o,
    output logic [IW-1:0] iter_o
);

    seq_ctl_t ctl;
    logic     hold_next_any;

    xbar_req_seq #(.NITER(NITER)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .slot_start_i (slot_start_i),
        .ctl_o        (ctl),
        .issue_o      (issue_o),
        .iter_o       (iter_o)
    );

    xbar_req_hold #(.N(N)) u_hold (
        .clk             (clk),
        .rst             (rst),
        .start_i         (ctl.start),
        .prev_i          (prev_conn_i),
        .keep_i          (keep_i),
        .voq_ne_i        (voq_ne_i),
        .hold_next_any_o (hold_next_any),
        .hold_o          (hold_dis_o)
    );

    xbar_req_lines #(.N(N)) u_lines (
        .clk             (clk),
        .rst             (rst),
        .ctl_i           (ctl),
        .hold_next_any_i (hold_next_any),
        .voq_ne_i        (voq_ne_i),
        .any_grant_i     (any_grant_i),
        .req_o           (req_o),
        .matched_o       (matched_o)
    );

    // R4
    grant_sets_match_chk: assert property (@(posedge clk) disable iff (rst)
        (any_grant_i && !slot_start_i) |=> matched_o);

    // R5
    idle_no_req_chk: assert property (@(posedge clk) disable iff (rst)
        !issue_o |-> (req_o == '0));

    // R6
    held_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_dis_o != '0) |-> (matched_o && (req_o == '0)));

    // R6
    held_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(prev_conn_i) |=> $onehot0(hold_dis_o) || $past(!slot_start_i));

endmodule

// File: tb/xbar_req_gen_tb.sv
module xbar_req_gen_tb;

    localparam int N     = 4;
    localparam int NITER = 3;
    localparam int IW    = (NITER > 1) ? $clog2(NITER) : 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          slot_start = 1'b0;
    logic [N-1:0]  voq = '0;
    logic          any_grant = 1'b0;
    logic [N-1:0]  prev_conn = '0;
    logic [N-1:0]  keep = '0;
    logic [N-1:0]  req;
    logic [N-1:0]  hold_dis;
    logic          matched;
    logic          issue;
    logic [IW-1:0] iter;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    xbar_req_gen #(.N(N), .NITER(NITER)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .slot_start_i (slot_start),
        .voq_ne_i     (voq),
        .any_grant_i  (any_grant),
        .prev_conn_i  (prev_conn),
        .keep_i       (keep),
        .req_o        (req),
        .hold_dis_o   (hold_dis),
        .matched_o    (matched),
        .issue_o      (issue),
        .iter_o       (iter)
    );

    // behavioural reference
    logic [N-1:0] m_req, m_hold;
    bit m_match, m_busy;
    int m_left, m_idx;

    always @(posedge clk) begin
        if (rst) begin
            m_req = '0; m_hold = '0; m_match = 0; m_busy = 0; m_left = 0; m_idx = 0;
        end else if (slot_start) begin
            m_hold  = prev_conn & keep & voq;
            m_match = (m_hold != '0);
            m_req   = m_match ? '0 : voq;
            m_busy  = 1; m_left = NITER - 1; m_idx = 0;
        end else begin
            m_match = m_match || any_grant;
            if (m_busy && m_left > 0) begin
                m_req = m_match ? '0 : voq;
                m_left--; m_idx++;
            end else begin
                m_req = '0; m_busy = 0; m_idx = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            n_cmp++;
            if (req !== m_req || hold_dis !== m_hold || matched !== m_match ||
                issue !== m_busy || int'(iter) != m_idx) begin
                n_bad++;
                $display("FAIL R3 model compare t=%0t: req=%b/%b hold=%b/%b match=%b/%b issue=%b/%b iter=%0d/%0d",
                         $time, req, m_req, hold_dis, m_hold, matched, m_match,
                         issue, m_busy, iter, m_idx);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #0.5;
    endtask

    task automatic pulse_slot();
        slot_start = 1'b1;
        step();
        slot_start = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #40000;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) step();
        chk("R1 req in reset", int'(req), 0);
        chk("R1 matched in reset", int'(matched), 0);
        rst = 1'b0;
        step();
        chk("R1 hold after reset", int'(hold_dis), 0);
        chk("R1 issue after reset", int'(issue), 0);

        // plain slot
        voq = 4'b1011;
        pulse_slot();
        chk("R2 req first iter", int'(req), 4'b1011);
        chk("R2 iter index", int'(iter), 0);
        chk("R2 unmatched", int'(matched), 0);
        voq = 4'b0110;
        step();
        chk("R3 req follows queues", int'(req), 4'b0110);
        chk("R5 second iter", int'(iter), 1);
        step();
        chk("R5 third iter", int'(iter), 2);
        step();
        chk("R5 phase ends", int'(issue), 0);
        chk("R5 req cleared", int'(req), 0);
        step();

        // grant stops requests
        voq = 4'b1111;
        pulse_slot();
        chk("R3 req full", int'(req), 4'b1111);
        any_grant = 1'b1;
        step();
        any_grant = 1'b0;
        chk("R4 matched after grant", int'(matched), 1);
        chk("R4 req silent", int'(req), 0);
        step();
        chk("R4 still silent", int'(req), 0);
        repeat (2) step();

        // kept connection
        prev_conn = 4'b0100; keep = 4'b0100; voq = 4'b0101;
        pulse_slot();
        chk("R6 hold vector", int'(hold_dis), 4'b0100);
        chk("R6 matched by hold", int'(matched), 1);
        chk("R6 no requests", int'(req), 0);
        prev_conn = '0; keep = '0;
        step();
        chk("R8 hold stable", int'(hold_dis), 4'b0100);
        chk("R6 still silent", int'(req), 0);
        repeat (2) step();

        // kept connection dropped on empty queue
        prev_conn = 4'b0010; keep = 4'b0010; voq = 4'b1101;
        pulse_slot();
        chk("R7 hold dropped", int'(hold_dis), 0);
        chk("R7 unmatched", int'(matched), 0);
        chk("R7 requests", int'(req), 4'b1101);
        prev_conn = '0; keep = '0;

        // restart mid slot
        any_grant = 1'b1;
        step();
        any_grant = 1'b0;
        chk("R9 matched before restart", int'(matched), 1);
        voq = 4'b0011;
        pulse_slot();
        chk("R9 matched cleared", int'(matched), 0);
        chk("R9 req reissued", int'(req), 4'b0011);
        chk("R9 iter restarted", int'(iter), 0);
        repeat (4) step();

        // random traffic against the model
        for (int s = 0; s < 150; s++) begin
            int gap;
            int pick;
            gap  = 1 + int'($urandom_range(NITER + 2));
            pick = int'($urandom_range(N - 1));
            voq        = N'($urandom);
            prev_conn  = ($urandom_range(1) != 0) ? N'(1 << pick) : '0;
            keep       = N'($urandom);
            slot_start = 1'b1;
            step();
            slot_start = 1'b0;
            prev_conn  = '0;
            for (int c = 0; c < gap; c++) begin
                voq       = N'($urandom);
                any_grant = ($urandom_range(3) == 0);
                step();
            end
            any_grant = 1'b0;
        end
        repeat (4) step();
        finish_run();
    end

endmodule